// File: doc/BRIEF.md
# Fuse Bank Lock and Access Gate

This block guards a set of one-time-programmable fuse banks that are mirrored in shadow registers. Every request arrives on a single register-style port. The request names an operation, a bank and a data word. The block answers one cycle later with a response flag, an error bit and a data word.

Each bank carries four sticky lock bits. Each lock closes one access path:

- programming of the fuse word;
- software reads of the shadow;
- writes to the shadow;
- the hardware read path, which then returns zero instead of an error.

A per-bank parameter sets how the bank programs:

- An incremental bank lets fuse bits go from 0 to 1 over any number of program operations, and never back.
- An ECC-protected bank takes exactly one whole-word program.

A program that is accepted loads both the fuse word and its shadow. The physical fuse timing and the ECC code generation sit outside the block. Lock bits are set through a dedicated lock operation and clear only on reset.

Top module: `fuse_lock_gate`

## Requirements
- R1: Operation code 0 programs a bank. It is refused when that bank's program lock (lock bit 0) is set, and the bank's content is left unchanged.
- R2: Operation code 1 is a software read that returns the bank's shadow word. It is refused when the read lock (lock bit 1) is set.
- R3: Operation code 2 writes the shadow word. It is refused when the shadow lock (lock bit 2) is set. When accepted, it changes what later software and hardware reads return.
- R4: Operation code 3 is a hardware read. It never reports an error. It returns all zeros while the hardware lock (lock bit 3) is set, and returns the shadow word otherwise.
- R5: On an incremental bank, a program whose data keeps every bit that is already 1 is accepted, and the stored word becomes the request data.
- R6: On an incremental bank, a program that would clear any bit that is already 1 is refused, and the stored word is unchanged.
- R7: On an ECC bank, the first program is accepted. Every later program is refused and leaves the stored word unchanged.
- R8: Operation code 4 ORs the request data bits 3..0 into the bank's lock bits and never errs. Lock bits never clear except on reset.
- R9: A refused request returns the error bit set and a data word of all zeros. Accepted writes and lock operations return zero data with no error.
- R10: Every request cycle produces exactly one response, with rsp_valid set in the following cycle. An idle cycle produces no response.
- R11: Operation codes 5 to 7, and bank indices at or above NUM_BANKS, are refused with an error and change nothing.
- R12: After reset, no response is pending, all fuse and shadow words are zero, and all locks are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Operation: 0 program, 1 software read, 2 shadow write, 3 hardware read, 4 lock set |
| req_bank | input | BANK_W | Bank index |
| req_data | input | DATA_W | Program, shadow or lock-mask data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | Request was refused |
| rsp_data | output | DATA_W | Read data; zero for refused requests and for writes |

## Verification
The bench builds the block with three banks of 4-bit words: banks 0 and 2 are incremental and bank 1 is ECC-protected. The 2-bit bank index then reaches the invalid index 3.

With 4-bit words, every pair of first and second program values can be swept on both bank kinds, so the 0-to-1 rule and the write-once rule are covered completely. All 16 lock masks are also swept. Each mask is followed by every operation and a second, empty lock operation, which shows that the locks are sticky.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int LOCK_W = 4;

  typedef enum logic [2:0] {
    OP_PROG  = 3'd0,
    OP_SREAD = 3'd1,
    OP_SHWR  = 3'd2,
    OP_HREAD = 3'd3,
    OP_LOCK  = 3'd4
  } op_e;

  // bit 0 program, bit 1 soft read, bit 2 shadow write, bit 3 hardware read
  typedef struct packed {
    logic hw;
    logic shadow;
    logic rd;
    logic prog;
  } lock_t;
endpackage

// File: rtl/flg_bank.sv
module flg_bank
  import flg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit INCR   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  op_e               op,
  input  logic [DATA_W-1:0] wdata,
  output logic              ok,
  output logic [DATA_W-1:0] shadow_o,
  output lock_t             lock_o
);
  logic [DATA_W-1:0] fuse_q, fuse_d;
  logic [DATA_W-1:0] shadow_q, shadow_d;
  lock_t             lock_q, lock_d;
  logic              fuse_en, shadow_en, lock_en;
  logic              prog_ok;

  // programming rule picked per bank
  generate
    if (INCR) begin : g_incr
      assign prog_ok = !lock_q.prog && ((fuse_q & ~wdata) == '0);
    end else begin : g_ecc
      logic used_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       used_q <= 1'b0;
        else if (fuse_en) used_q <= 1'b1;
      end
      assign prog_ok = !lock_q.prog && !used_q;
    end
  endgenerate

  always_comb begin
    case (op)
      OP_PROG:  ok = prog_ok;
      OP_SREAD: ok = !lock_q.rd;
      OP_SHWR:  ok = !lock_q.shadow;
      OP_HREAD: ok = 1'b1;
      OP_LOCK:  ok = 1'b1;
      default:  ok = 1'b0;
    endcase
    fuse_en   = sel && ok && (op == OP_PROG);
    shadow_en = sel && ok && ((op == OP_PROG) || (op == OP_SHWR));
    lock_en   = sel && (op == OP_LOCK);
    fuse_d    = wdata;
    shadow_d  = wdata;
    lock_d    = lock_q | lock_t'(wdata[LOCK_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fuse_q <= '0;
    else if (fuse_en) fuse_q <= fuse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (shadow_en) shadow_q <= shadow_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= '0;
    else if (lock_en) lock_q <= lock_d;
  end

  assign shadow_o = shadow_q;
  assign lock_o   = lock_q;
endmodule

// File: rtl/flg_rsp.sv
module flg_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_err,
  input  logic [DATA_W-1:0] in_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data
);
  logic              valid_d, err_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    valid_d = in_valid;
    err_d   = in_valid && in_err;
    data_d  = (in_valid && !in_err) ? in_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_err   <= err_d;
      rsp_data  <= data_d;
    end
  end
endmodule

// File: rtl/fuse_lock_gate.sv
module fuse_lock_gate
  import flg_pkg::*;
#(
  parameter int                  NUM_BANKS = 8,
  parameter int                  DATA_W    = 32,
  parameter logic [NUM_BANKS-1:0] INCR_MASK = 8'h0F,
  localparam int                 BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data
);
  localparam logic [BANK_W:0] NB = NUM_BANKS[BANK_W:0];

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1 <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_n  <= rst_s1;
    end
  end

  op_e               op;
  logic              op_known, bank_in;
  logic [NUM_BANKS-1:0] bank_ok;
  logic [DATA_W-1:0] bank_shadow [NUM_BANKS];
  lock_t             bank_lock   [NUM_BANKS];
  logic [LOCK_W*NUM_BANKS-1:0] lock_flat;

  assign op       = op_e'(req_op);
  assign op_known = (req_op <= 3'd4);
  assign bank_in  = ({1'b0, req_bank} < NB);

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic sel;
      assign sel = req_valid && op_known && bank_in &&
                   (req_bank == g[BANK_W-1:0]);
      flg_bank #(
        .DATA_W (DATA_W),
        .INCR   (INCR_MASK[g])
      ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .op       (op),
        .wdata    (req_data),
        .ok       (bank_ok[g]),
        .shadow_o (bank_shadow[g]),
        .lock_o   (bank_lock[g])
      );
      assign lock_flat[g*LOCK_W +: LOCK_W] = bank_lock[g];
    end
  endgenerate

  logic              cur_ok;
  logic [DATA_W-1:0] cur_shadow;
  lock_t             cur_lock;
  logic              acc_err;
  logic [DATA_W-1:0] acc_data;

  always_comb begin
    cur_ok     = 1'b0;
    cur_shadow = '0;
    cur_lock   = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (req_bank == i[BANK_W-1:0]) begin
        cur_ok     = bank_ok[i];
        cur_shadow = bank_shadow[i];
        cur_lock   = bank_lock[i];
      end
    end
    acc_err = !(op_known && bank_in && cur_ok);
    case (op)
      OP_SREAD: acc_data = cur_shadow;
      OP_HREAD: acc_data = cur_lock.hw ? '0 : cur_shadow;
      default:  acc_data = '0;
    endcase
  end

  flg_rsp #(.DATA_W(DATA_W)) rsp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_err    (acc_err),
    .in_data   (acc_data),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/flg_checker.sv
module flg_checker #(
  parameter int NUM_BANKS = 8,
  parameter int DATA_W    = 32,
  parameter int BANK_W    = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [2:0]              req_op,
  input logic [BANK_W-1:0]       req_bank,
  input logic                    rsp_valid,
  input logic                    rsp_err,
  input logic [DATA_W-1:0]       rsp_data,
  input logic [4*NUM_BANKS-1:0]  lock_flat
);
  localparam logic [BANK_W:0] NB = NUM_BANKS[BANK_W:0];
  logic in_rng;
  assign in_rng = ({1'b0, req_bank} < NB);

  p_prog_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0 && in_rng && lock_flat[{req_bank, 2'd0}])
      |=> (rsp_valid && rsp_err));

  p_read_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1 && in_rng && lock_flat[{req_bank, 2'd1}])
      |=> (rsp_err && rsp_data == '0));

  p_shadow_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2 && in_rng && lock_flat[{req_bank, 2'd2}])
      |=> rsp_err);

  p_hw_lock_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3 && in_rng && lock_flat[{req_bank, 2'd3}])
      |=> (!rsp_err && rsp_data == '0));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_flat & $past(lock_flat)) == $past(lock_flat)));

  p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_bad_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op > 3'd4 || !in_rng)) |=> rsp_err);
endmodule

bind fuse_lock_gate flg_checker #(
  .NUM_BANKS (NUM_BANKS),
  .DATA_W    (DATA_W),
  .BANK_W    (BANK_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_bank  (req_bank),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data),
  .lock_flat (lock_flat)
);

// File: tb/fuse_lock_gate_tb_top.sv
module fuse_lock_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       req_valid;
  logic [2:0] req_op;
  logic [1:0] req_bank;
  logic [3:0] req_data;
  logic       rsp_valid, rsp_err;
  logic [3:0] rsp_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  fuse_lock_gate #(
    .NUM_BANKS (3),
    .DATA_W    (4),
    .INCR_MASK (3'b101)
  ) dut_i (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_bank  (req_bank),
    .req_data  (req_data),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data)
  );

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni    = 1'b0;
    req_valid = 1'b0;
    req_op    = '0;
    req_bank  = '0;
    req_data  = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_req(input logic [2:0] op, input logic [1:0] bank,
                        input logic [3:0] data, output logic e, output logic [3:0] d);
    req_valid = 1'b1;
    req_op    = op;
    req_bank  = bank;
    req_data  = data;
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R10 rsp_valid after request", rsp_valid, 1);
    e = rsp_err;
    d = rsp_data;
    req_valid = 1'b0;
  endtask

  // request, then check error bit and data together
  task automatic req_chk(input logic [2:0] op, input logic [1:0] bank, input logic [3:0] data,
                         input logic exp_e, input logic [3:0] exp_d, input string tag);
    logic e;
    logic [3:0] d;
    do_req(op, bank, data, e, d);
    chk(e === exp_e, {tag, " err"}, e, exp_e);
    chk(d === exp_d, {tag, " data"}, d, exp_d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni    = 1'b0;
    req_valid = 1'b0;
    req_op    = '0;
    req_bank  = '0;
    req_data  = '0;

    // R12 reset state
    do_reset();
    chk(rsp_valid === 1'b0, "R12 no response after reset", rsp_valid, 0);
    for (int b = 0; b < 3; b++)
      req_chk(3'd1, 2'(b), 4'h0, 1'b0, 4'h0, "R12 reset shadow zero");
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10 idle cycle no response", rsp_valid, 0);

    // R11 bad op codes and out-of-range bank
    for (int o = 5; o < 8; o++)
      req_chk(3'(o), 2'd0, 4'hF, 1'b1, 4'h0, "R11 unknown op");
    req_chk(3'd0, 2'd3, 4'hF, 1'b1, 4'h0, "R11 bank out of range");
    req_chk(3'd4, 2'd3, 4'hF, 1'b1, 4'h0, "R11 lock out of range");
    req_chk(3'd1, 2'd0, 4'h0, 1'b0, 4'h0, "R11 bank0 unchanged");
    req_chk(3'd0, 2'd0, 4'h1, 1'b0, 4'h0, "R11 bank0 program lock still clear");

    // R5 / R6 incremental banks 0 and 2: all pairs
    for (int bk = 0; bk < 3; bk += 2) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          bit acc;
          do_reset();
          acc = ((a & ~b) & 4'hF) == 0;
          req_chk(3'd0, 2'(bk), 4'(a), 1'b0, 4'h0, "R5 first program");
          req_chk(3'd0, 2'(bk), 4'(b), !acc, 4'h0, acc ? "R5 set-only program" : "R6 clearing program");
          req_chk(3'd1, 2'(bk), 4'h0, 1'b0, acc ? 4'(b) : 4'(a), acc ? "R5 read after program" : "R6 word unchanged");
        end
      end
    end

    // R7 ECC bank 1: write once
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        req_chk(3'd0, 2'd1, 4'(a), 1'b0, 4'h0, "R7 first program");
        req_chk(3'd0, 2'd1, 4'(b), 1'b1, 4'h0, "R7 second program refused");
        req_chk(3'd1, 2'd1, 4'h0, 1'b0, 4'(a), "R7 word unchanged");
      end
    end

    // R1-style lock sweep on incremental bank 0 with all masks
    for (int m = 0; m < 16; m++) begin
      logic [3:0] cur;
      bit pl, rl, sl, hl;
      pl = m[0]; rl = m[1]; sl = m[2]; hl = m[3];
      do_reset();
      req_chk(3'd0, 2'd0, 4'h1, 1'b0, 4'h0, "R5 initial program");
      req_chk(3'd4, 2'd0, 4'(m), 1'b0, 4'h0, "R8 lock op accepted");
      req_chk(3'd0, 2'd0, 4'h3, pl, 4'h0, "R1 program under lock");
      cur = pl ? 4'h1 : 4'h3;
      req_chk(3'd1, 2'd0, 4'h0, rl, rl ? 4'h0 : cur, "R2 soft read under lock");
      req_chk(3'd2, 2'd0, 4'h7, sl, 4'h0, "R3 shadow write under lock");
      if (!sl) cur = 4'h7;
      req_chk(3'd3, 2'd0, 4'h0, 1'b0, hl ? 4'h0 : cur, "R4 hardware read");
      req_chk(3'd1, 2'd0, 4'h0, rl, rl ? 4'h0 : cur, "R3 soft read after shadow write");
      req_chk(3'd4, 2'd0, 4'h0, 1'b0, 4'h0, "R8 empty lock op");
      req_chk(3'd1, 2'd0, 4'h0, rl, rl ? 4'h0 : cur, "R8 read lock sticky");
      req_chk(3'd0, 2'd0, 4'hF, pl, 4'h0, "R8 program lock sticky");
      if (!pl) cur = 4'hF;
      req_chk(3'd3, 2'd0, 4'h0, 1'b0, hl ? 4'h0 : cur, "R8 hw lock sticky");
      // other bank untouched by this bank's locks
      req_chk(3'd1, 2'd2, 4'h0, 1'b0, 4'h0, "R8 locks per bank");
    end

    // R9 refused reads carry zero data even with content present
    do_reset();
    req_chk(3'd0, 2'd1, 4'hA, 1'b0, 4'h0, "R9 setup");
    req_chk(3'd4, 2'd1, 4'h2, 1'b0, 4'h0, "R9 lock read");
    req_chk(3'd1, 2'd1, 4'h0, 1'b1, 4'h0, "R9 refused read zero data");
    req_chk(3'd3, 2'd1, 4'h0, 1'b0, 4'hA, "R4 hw read open without hw lock");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule